// File: doc/BRIEF.md
# Variable Bit-Field Extract Unit

This block pulls a contiguous run of 0 to 32 bits out of a 64-bit source window. The run can start at any bit offset from 0 to 31, with no regard to byte boundaries, so a full 32-bit run can reach into the upper half of the window. The bits come back right-aligned in a 32-bit longword, which is zero-filled or sign-filled above the run as the caller chooses.

A second mode compares the widened field with a 32-bit operand. In that mode the block sets condition flags instead of returning a value. A field size above 32 is illegal and raises a fault flag.

The caller presents the window, offset, size, fill choice, mode and operand together with a one-cycle `start` pulse. The outputs are registered. They appear one cycle later with `res_valid` and then hold until the next `start`.

Top module: `bfx_unit`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle in which `start` is high, and is low at all other times.
- R2: With `sign_ext` = 0, `result` bit i equals `src_win` bit (`bit_pos` + i) for i < `field_size`, and every bit from `field_size` upward is 0.
- R3: With `sign_ext` = 1 and `field_size` from 1 to 31, every `result` bit from `field_size` upward equals `src_win` bit (`bit_pos` + `field_size` − 1).
- R4: With `field_size` = 32, `result` is `src_win[bit_pos+31:bit_pos]`, whatever `sign_ext` is, including offsets where the field crosses into bits 32..63.
- R5: With `field_size` = 0, the extended field is 0. In extract mode `result` = 0, `flag_z` = 1 and `flag_n` = 0.
- R6: A `field_size` greater than 32 sets `rsvd_fault` = 1, with `result` = 0 and all three flags 0. A legal size clears `rsvd_fault`.
- R7: In extract mode (`cmp_mode` = 0), `flag_n` = `result[31]`, `flag_z` = (`result` == 0) and `flag_c` = 0.
- R8: In compare mode (`cmp_mode` = 1), `result` = 0. `flag_n` = 1 when the extended field is less than `cmp_operand` as signed 32-bit numbers. `flag_z` = 1 when they are equal. `flag_c` = 1 when the field is less than `cmp_operand` as unsigned numbers.
- R9: While `rst_n` is low, `res_valid`, `result`, `rsvd_fault` and the flags are all 0.
- R10: In a cycle that follows a cycle without `start`, `result`, the flags and `rsvd_fault` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; all operands are sampled in this cycle |
| cmp_mode | input | 1 | 0 = extract, 1 = compare against `cmp_operand` |
| sign_ext | input | 1 | 1 = sign-fill above the field, 0 = zero-fill |
| bit_pos | input | 5 | Offset of the field's lowest bit in the window |
| field_size | input | 6 | Field width in bits; values above 32 are illegal |
| src_win | input | 64 | Source bit window |
| cmp_operand | input | 32 | Longword compared in compare mode |
| res_valid | output | 1 | High for one cycle when new outputs are present |
| result | output | 32 | Extended field (extract mode), otherwise 0 |
| flag_n | output | 1 | Negative / signed-less flag |
| flag_z | output | 1 | Zero / equal flag |
| flag_c | output | 1 | Unsigned-less (borrow) flag; 0 in extract mode |
| rsvd_fault | output | 1 | Illegal field size flag |

## Verification
The mask, the shift and the fill are each internal state that the ports expose. A wrong mask or shift shows up as wrong bits in `result` in the very cycle `res_valid` rises, for any offset and size that touch the faulty bit. A fill error shows in the upper bits of `result` once a negative field is read with `sign_ext` set. A broken compare path shows only in the flags, because `result` is 0 in that mode, so the bench picks operand pairs where the signed and unsigned orderings disagree. A faulty hold enable shows up on the first idle cycle after a result.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned BFX_LW    = 32;
  localparam int unsigned BFX_WIN_W = 64;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } bfx_flags_t;
endpackage

// File: rtl/bfx_align.sv
module bfx_align #(
  parameter int unsigned LW    = 32,
  parameter int unsigned WIN_W = 64
) (
  input  logic [WIN_W-1:0]       src_win,
  input  logic [$clog2(LW)-1:0]  bit_pos,
  input  logic [$clog2(LW):0]    field_size,
  output logic [LW-1:0]          field,
  output logic [LW-1:0]          mask
);
  localparam int unsigned SZW = $clog2(LW) + 1;

  logic [WIN_W-1:0] shifted;
  logic [LW:0]      one_at_size;

  always_comb begin
    shifted     = src_win >> bit_pos;
    one_at_size = (LW+1)'(1) << field_size;
    // a size of LW wraps to zero here, so subtracting one gives all ones
    mask        = one_at_size[LW-1:0] - LW'(1);
    field       = shifted[LW-1:0] & mask;
  end

  logic unused_sz;
  assign unused_sz = ^{shifted[WIN_W-1:LW], one_at_size[LW], SZW'(0)};
endmodule

// File: rtl/bfx_extend.sv
module bfx_extend #(
  parameter int unsigned LW = 32
) (
  input  logic [LW-1:0] field,
  input  logic [LW-1:0] mask,
  input  logic          sign_ext,
  output logic [LW-1:0] ext
);
  logic [LW-1:0] top_bit;
  logic          sbit;

  always_comb begin
    top_bit = mask & ~(mask >> 1);
    sbit    = |(field & top_bit);
    ext     = (sign_ext && sbit) ? (field | ~mask) : field;
  end

  // R2: zero fill leaves nothing above the field
  always_comb begin
    if (!sign_ext) begin
      p_zero_above_r2: assert ((ext & ~mask) == '0);
    end
  end
endmodule

// File: rtl/bfx_compare.sv
module bfx_compare
  import bfx_pkg::*;
#(
  parameter int unsigned LW = 32
) (
  input  logic [LW-1:0] ext,
  input  logic [LW-1:0] operand,
  output bfx_flags_t    flags
);
  logic [LW:0] diff;

  always_comb begin
    diff    = {1'b0, ext} - {1'b0, operand};
    flags.c = diff[LW];
    flags.z = (diff[LW-1:0] == '0);
    flags.n = (ext[LW-1] ^ operand[LW-1]) ? ext[LW-1] : diff[LW-1];
  end

  // R8: equality excludes both less-than outcomes
  always_comb begin
    if (flags.z) begin
      p_eq_excl_r8: assert (!flags.n && !flags.c);
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned LW    = BFX_LW,
  parameter int unsigned WIN_W = BFX_WIN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   cmp_mode,
  input  logic                   sign_ext,
  input  logic [$clog2(LW)-1:0]  bit_pos,
  input  logic [$clog2(LW):0]    field_size,
  input  logic [WIN_W-1:0]       src_win,
  input  logic [LW-1:0]          cmp_operand,
  output logic                   res_valid,
  output logic [LW-1:0]          result,
  output logic                   flag_n,
  output logic                   flag_z,
  output logic                   flag_c,
  output logic                   rsvd_fault
);
  localparam int unsigned SZW = $clog2(LW) + 1;

  logic [LW-1:0] field, mask, ext;
  bfx_flags_t    cmp_flags;
  logic          oversize;

  bfx_align #(.LW(LW), .WIN_W(WIN_W)) u_align (
    .src_win(src_win), .bit_pos(bit_pos), .field_size(field_size),
    .field(field), .mask(mask)
  );

  bfx_extend #(.LW(LW)) u_extend (
    .field(field), .mask(mask), .sign_ext(sign_ext), .ext(ext)
  );

  bfx_compare #(.LW(LW)) u_cmp (
    .ext(ext), .operand(cmp_operand), .flags(cmp_flags)
  );

  assign oversize = (field_size > SZW'(LW));

  logic          valid_q, valid_d;
  logic          fault_q, fault_d;
  logic          cmp_q, cmp_d;
  logic [LW-1:0] res_q, res_d;
  bfx_flags_t    flg_q, flg_d;
  logic          upd_en;

  assign upd_en = start;

  always_comb begin
    valid_d = start;
    fault_d = fault_q;
    cmp_d   = cmp_q;
    res_d   = res_q;
    flg_d   = flg_q;
    if (upd_en) begin
      fault_d = oversize;
      cmp_d   = cmp_mode;
      if (oversize) begin
        res_d = '0;
        flg_d = '0;
      end else if (cmp_mode) begin
        res_d = '0;
        flg_d = cmp_flags;
      end else begin
        res_d   = ext;
        flg_d.n = ext[LW-1];
        flg_d.z = (ext == '0);
        flg_d.c = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      cmp_q   <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      cmp_q   <= cmp_d;
      res_q   <= res_d;
      flg_q   <= flg_d;
    end
  end

  assign res_valid  = valid_q;
  assign result     = res_q;
  assign flag_n     = flg_q.n;
  assign flag_z     = flg_q.z;
  assign flag_c     = flg_q.c;
  assign rsvd_fault = fault_q;

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(rsvd_fault) && $stable(flag_z)));
  p_oversize_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && oversize) |=> (rsvd_fault && result == '0 && !flag_n && !flag_z && !flag_c));
  p_extract_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !rsvd_fault && !cmp_q) |->
      (flag_n == result[LW-1] && flag_z == (result == '0) && !flag_c));
  p_cmp_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_q) |-> (result == '0));
endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, cmp_mode, sign_ext;
  logic [4:0]  bit_pos;
  logic [5:0]  field_size;
  logic [63:0] src_win;
  logic [31:0] cmp_operand;
  logic        res_valid, flag_n, flag_z, flag_c, rsvd_fault;
  logic [31:0] result;

  bfx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_mode(cmp_mode),
    .sign_ext(sign_ext), .bit_pos(bit_pos), .field_size(field_size),
    .src_win(src_win), .cmp_operand(cmp_operand), .res_valid(res_valid),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .rsvd_fault(rsvd_fault)
  );

  typedef struct {
    logic [31:0] res;
    logic        n, z, c, f;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last;
  bit   have_last = 0;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(input logic [4:0] p, input logic [5:0] s,
                                 input logic se, input logic cm,
                                 input logic [63:0] w, input logic [31:0] op,
                                 input string tag);
    exp_t e;
    logic [31:0] f;
    f = '0;
    e.tag = tag;
    if (s > 32) begin
      e.res = 0; e.n = 0; e.z = 0; e.c = 0; e.f = 1;
      return e;
    end
    for (int i = 0; i < 32; i++) begin
      if (i < int'(s)) f[i] = w[int'(p) + i];
      else if (se && s != 0) f[i] = w[int'(p) + int'(s) - 1];
    end
    e.f = 0;
    if (cm) begin
      e.res = 0;
      e.n = ($signed(f) < $signed(op));
      e.z = (f == op);
      e.c = (f < op);
    end else begin
      e.res = f; e.n = f[31]; e.z = (f == 0); e.c = 0;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p, input logic [5:0] s, input logic se,
                       input logic cm, input logic [63:0] w, input logic [31:0] op,
                       input string tag);
    @(negedge clk);
    bit_pos = p; field_size = s; sign_ext = se; cmp_mode = cm;
    src_win = w; cmp_operand = op; start = 1;
    exp_q.push_back(model(p, s, se, cm, w, op, tag));
    @(negedge clk);
    start = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R1", "valid without request", 32'(res_valid), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(result == e.res, e.tag, "result", result, e.res);
          check({flag_n, flag_z, flag_c} == {e.n, e.z, e.c}, e.tag, "flags nzc",
                32'({flag_n, flag_z, flag_c}), 32'({e.n, e.z, e.c}));
          check(rsvd_fault == e.f, e.tag, "fault", 32'(rsvd_fault), 32'(e.f));
          last = e; have_last = 1;
        end
      end else if (have_last) begin
        check(result == last.res && rsvd_fault == last.f &&
              {flag_n, flag_z, flag_c} == {last.n, last.z, last.c},
              "R10", "hold result", result, last.res);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; cmp_mode = 0; sign_ext = 0; bit_pos = 0;
    field_size = 0; src_win = 0; cmp_operand = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!res_valid && result == 0 && !flag_n && !flag_z && !flag_c && !rsvd_fault,
          "R9", "reset outputs", result, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(!res_valid, "R1", "idle valid", 32'(res_valid), 0);

    drive(5'd0,  6'd8,  0, 0, 64'h0000_0000_0000_00A5, 0, "R2");
    drive(5'd0,  6'd8,  1, 0, 64'h0000_0000_0000_00A5, 0, "R3");
    drive(5'd29, 6'd7,  0, 0, 64'h0123_4567_89AB_CDEF, 0, "R2");
    drive(5'd29, 6'd7,  1, 0, 64'hFFFF_FFFF_E000_0000, 0, "R3");
    drive(5'd3,  6'd1,  1, 0, 64'h0000_0000_0000_0008, 0, "R3");
    drive(5'd17, 6'd32, 0, 0, 64'hDEAD_BEEF_CAFE_F00D, 0, "R4");
    drive(5'd31, 6'd32, 1, 0, 64'h8000_0001_8000_0000, 0, "R4");
    drive(5'd12, 6'd0,  1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5");
    drive(5'd4,  6'd33, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6");
    drive(5'd0,  6'd63, 1, 1, 64'h1234, 32'h5, "R6");
    drive(5'd4,  6'd8,  0, 0, 64'h0000_0000_0000_0000, 0, "R7");
    drive(5'd0,  6'd32, 0, 0, 64'h0000_0000_8000_0000, 0, "R7");
    drive(5'd0,  6'd32, 0, 1, 64'h0000_0000_FFFF_FFFF, 32'h1, "R8");
    drive(5'd0,  6'd32, 0, 1, 64'h1, 32'hFFFF_FFFF, "R8");
    drive(5'd8,  6'd16, 1, 1, 64'h0000_0000_00FF_FF00, 32'hFFFF_FFFF, "R8");
    drive(5'd8,  6'd16, 0, 1, 64'h0000_0000_0012_3400, 32'h1235, "R8");
    drive(5'd2,  6'd0,  0, 1, 64'hFF, 32'h0, "R5");
    repeat (2) @(negedge clk);

    for (int k = 0; k < 60; k++) begin
      logic [5:0] sz;
      sz = 6'($urandom_range(0, 34));
      drive(5'($urandom), sz, 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, $urandom, sz > 32 ? "R6" : "R2");
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending results", 32'(exp_q.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule